// File: doc/BRIEF.md
# Shared Core Clock Modulation Controller

This block produces one clock-enable pulse pattern for a core that two hardware threads share. Each thread writes its own modulation setting, made of an enable bit and a 3-bit duty value. The block merges the two settings into one physical modulation. It also takes two thermal flags. A trip flag forces a fixed automatic slow-down. An overtemperature flag halts the core for both threads.

A clock-enable strobe stands in for the modulated clock: a duty value N gives N enabled cycles in every 8-cycle window. When the threads request different duties, the larger one is applied. Each thread's stored setting can be read back at all times. The halt output is visible to both threads and stays set until reset.

Top module: `clkmod_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `clk_en_o` is 1, `halt_o` is 0 and every readback field is 0.
- R2: A write with `wr_en`=1 stores `wr_data` into the setting of the thread given by `wr_thread`, and the readback shows it from the next cycle on. Bit 3 of a setting is the enable and bits 2:0 are the duty. Thread 0 occupies `rd_cfg_o[3:0]` and thread 1 occupies `rd_cfg_o[7:4]`.
- R3: A write to one thread leaves the other thread's stored setting and readback unchanged.
- R4: If no thread requests modulation and `thermal_trip` is 0, `clk_en_o` is 1 on every cycle.
- R5: With a single requesting thread of duty N (1 to 7), `clk_en_o` is 1 in the first N cycles of each 8-cycle window and 0 in the other 8−N cycles.
- R6: When both threads request modulation with different duties, the larger duty is applied.
- R7: A thread whose enable bit is 0 takes no part in the duty selection, whatever its duty field holds.
- R8: A duty field of 0 counts as no request, even when the enable bit is 1.
- R9: While `thermal_trip` is sampled as 1, the pattern is 4 enabled cycles out of 8, whatever the software settings are.
- R10: When `overtemp` is 1 at a clock edge, `halt_o` becomes 1 and `clk_en_o` becomes 0 at that edge. Both stay that way until reset, even after `overtemp` returns to 0.
- R11: Setting writes and `thermal_trip` are sampled only once per window, at its final cycle, so a change alters only whole windows and never cuts one short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Setting write strobe |
| wr_thread | input | 1 | Thread whose setting is written |
| wr_data | input | 4 | Setting: bit 3 enable, bits 2:0 duty |
| thermal_trip | input | 1 | Trip-threshold flag, forces automatic modulation |
| overtemp | input | 1 | Catastrophic overtemperature flag |
| clk_en_o | output | 1 | Gated clock-enable strobe for the shared core |
| halt_o | output | 1 | Sticky halt seen by both threads |
| rd_cfg_o | output | 8 | Readback of both thread settings |

## Verification
The hardest case to reach is a setting or trip change that lands in the middle of a window. The new value must reach the pattern exactly at the next window boundary and not one cycle earlier or later. From the ports this only shows up when writes and trip toggles arrive at arbitrary window phases. For that reason the stimulus includes a long stretch of writes to random threads and trip changes at pseudo-random intervals. A behavioural model in the bench follows its own window count and checks every cycle. Directed phases before that stretch set up the duty-merge cases. After it, a single-cycle overtemperature pulse shows that the halt stays set.

// File: rtl/clkmod_pkg.sv
package clkmod_pkg;
  // width of the duty field; the modulation window is 2**CM_DUTY_W cycles
  parameter int CM_DUTY_W = 3;
  localparam int CM_WIN   = 1 << CM_DUTY_W;
  localparam int CM_REG_W = CM_DUTY_W + 1;

  typedef struct packed {
    logic                 en;
    logic [CM_DUTY_W-1:0] duty;
  } thr_cfg_t;

  // fixed automatic thermal pattern: half of the window enabled
  localparam logic [CM_DUTY_W-1:0] CM_THERM_DUTY = CM_DUTY_W'(CM_WIN / 2);
endpackage

// File: rtl/clkmod_regs.sv
module clkmod_regs
  import clkmod_pkg::*;
#(
  parameter int NTHR  = 2,
  localparam int SEL_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  thr_cfg_t              wr_cfg,
  output thr_cfg_t [NTHR-1:0]   cfg
);
  // one storage slot per thread
  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[t] <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(t))) begin
        cfg[t] <= wr_cfg;
      end
    end
  end
endmodule

// File: rtl/clkmod_select.sv
module clkmod_select
  import clkmod_pkg::*;
#(
  parameter int NTHR = 2
) (
  input  thr_cfg_t [NTHR-1:0]   cfg,
  input  logic                  trip,
  output logic [CM_DUTY_W-1:0]  sel_duty,
  output logic                  sel_bypass
);
  logic [CM_DUTY_W-1:0] sw_max;
  logic                 sw_any;

  // largest requested duty among the threads that take part
  always_comb begin
    sw_max = '0;
    sw_any = 1'b0;
    for (int t = 0; t < NTHR; t++) begin
      if (cfg[t].en && (cfg[t].duty != '0)) begin
        sw_any = 1'b1;
        if (cfg[t].duty > sw_max) sw_max = cfg[t].duty;
      end
    end
  end

  // the thermal pattern overrides software modulation
  always_comb begin
    if (trip) begin
      sel_duty   = CM_THERM_DUTY;
      sel_bypass = 1'b0;
    end else if (sw_any) begin
      sel_duty   = sw_max;
      sel_bypass = 1'b0;
    end else begin
      sel_duty   = '0;
      sel_bypass = 1'b1;
    end
  end
endmodule

// File: rtl/clkmod_halt.sv
module clkmod_halt (
  input  logic clk,
  input  logic rst,
  input  logic overtemp,
  output logic halt_now,
  output logic halt_q
);
  assign halt_now = halt_q | overtemp;

  always_ff @(posedge clk) begin
    if (rst) halt_q <= 1'b0;
    else     halt_q <= halt_now;
  end
endmodule

// File: rtl/clkmod_window.sv
module clkmod_window
  import clkmod_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CM_DUTY_W-1:0]  sel_duty,
  input  logic                  sel_bypass,
  input  logic                  halt_now,
  output logic                  clk_en_q
);
  localparam logic [CM_DUTY_W-1:0] LAST_POS = CM_DUTY_W'(CM_WIN - 1);

  logic [CM_DUTY_W-1:0] pos;
  logic [CM_DUTY_W-1:0] lat_duty;
  logic                 lat_bypass;
  logic                 win_end;

  assign win_end = (pos == LAST_POS);

  // window position and the setting held for the whole window
  always_ff @(posedge clk) begin
    if (rst) begin
      pos        <= LAST_POS;
      lat_duty   <= '0;
      lat_bypass <= 1'b1;
    end else begin
      pos <= pos + 1'b1;
      if (win_end) begin
        lat_duty   <= sel_duty;
        lat_bypass <= sel_bypass;
      end
    end
  end

  // registered strobe
  always_ff @(posedge clk) begin
    if (rst) clk_en_q <= 1'b1;
    else     clk_en_q <= !halt_now && (lat_bypass || (pos < lat_duty));
  end
endmodule

// File: rtl/clkmod_ctrl.sv
module clkmod_ctrl
  import clkmod_pkg::*;
#(
  parameter int NTHR   = 2,
  localparam int SEL_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_thread,
  input  logic [CM_REG_W-1:0]      wr_data,
  input  logic                     thermal_trip,
  input  logic                     overtemp,
  output logic                     clk_en_o,
  output logic                     halt_o,
  output logic [NTHR*CM_REG_W-1:0] rd_cfg_o
);
  thr_cfg_t [NTHR-1:0]  cfg;
  logic [CM_DUTY_W-1:0] sel_duty;
  logic                 sel_bypass;
  logic                 halt_now;

  clkmod_regs #(.NTHR(NTHR)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_sel (wr_thread),
    .wr_cfg (thr_cfg_t'(wr_data)),
    .cfg    (cfg)
  );

  clkmod_select #(.NTHR(NTHR)) u_sel (
    .cfg        (cfg),
    .trip       (thermal_trip),
    .sel_duty   (sel_duty),
    .sel_bypass (sel_bypass)
  );

  clkmod_halt u_halt (
    .clk      (clk),
    .rst      (rst),
    .overtemp (overtemp),
    .halt_now (halt_now),
    .halt_q   (halt_o)
  );

  clkmod_window u_win (
    .clk        (clk),
    .rst        (rst),
    .sel_duty   (sel_duty),
    .sel_bypass (sel_bypass),
    .halt_now   (halt_now),
    .clk_en_q   (clk_en_o)
  );

  for (genvar t = 0; t < NTHR; t++) begin : g_rd
    assign rd_cfg_o[t*CM_REG_W +: CM_REG_W] = cfg[t];
  end
endmodule

// File: rtl/clkmod_ctrl_chk.sv
module clkmod_ctrl_chk
  import clkmod_pkg::*;
#(
  parameter int NTHR   = 2,
  localparam int SEL_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic [SEL_W-1:0]         wr_thread,
  input logic [CM_REG_W-1:0]      wr_data,
  input logic                     overtemp,
  input logic                     clk_en_o,
  input logic                     halt_o,
  input logic [NTHR*CM_REG_W-1:0] rd_cfg_o
);
  // R10: the halt is sticky
  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    halt_o |=> halt_o);

  // R10: an overtemperature sample sets the halt
  p_overtemp_sets_r10: assert property (@(posedge clk) disable iff (rst)
    overtemp |=> halt_o);

  // R10: no enable pulses while halted
  p_halt_gates_r10: assert property (@(posedge clk) disable iff (rst)
    halt_o |-> !clk_en_o);

  // R2: written value appears on thread 0 readback
  p_write_t0_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_thread == '0) |=> rd_cfg_o[CM_REG_W-1:0] == $past(wr_data));

  // R3: write to thread 0 leaves thread 1 untouched
  p_other_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_thread == '0) |=> $stable(rd_cfg_o[2*CM_REG_W-1:CM_REG_W]));
endmodule

bind clkmod_ctrl clkmod_ctrl_chk #(.NTHR(NTHR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_thread (wr_thread),
  .wr_data   (wr_data),
  .overtemp  (overtemp),
  .clk_en_o  (clk_en_o),
  .halt_o    (halt_o),
  .rd_cfg_o  (rd_cfg_o)
);

// File: tb/clkmod_ctrl_tb.sv
`timescale 1ns/1ps
module clkmod_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [0:0] wr_thread = 1'b0;
  logic [3:0] wr_data = 4'h0;
  logic       thermal_trip = 1'b0;
  logic       overtemp = 1'b0;
  logic       clk_en_o;
  logic       halt_o;
  logic [7:0] rd_cfg_o;

  int total = 0;
  int bad = 0;
  string phase = "R1";
  bit started = 1'b0;
  bit finished = 1'b0;

  // behavioural model state
  int m_pos, m_duty, m_halt, m_en;
  bit m_byp;
  int m_reg [2];

  always #2.5 clk = ~clk;

  clkmod_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_thread(wr_thread),
    .wr_data(wr_data), .thermal_trip(thermal_trip), .overtemp(overtemp),
    .clk_en_o(clk_en_o), .halt_o(halt_o), .rd_cfg_o(rd_cfg_o)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference: every edge
  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_pos = 7; m_duty = 0; m_byp = 1; m_halt = 0; m_en = 1;
      m_reg[0] = 0; m_reg[1] = 0;
    end else begin
      int hn, best;
      bit any;
      hn = (m_halt != 0 || overtemp) ? 1 : 0;
      m_en = (hn == 0 && (m_byp || m_pos < m_duty)) ? 1 : 0;
      if (m_pos == 7) begin
        best = 0; any = 0;
        for (int t = 0; t < 2; t++)
          if (m_reg[t][3] && (m_reg[t] & 7) != 0) begin
            any = 1;
            if ((m_reg[t] & 7) > best) best = m_reg[t] & 7;
          end
        if (thermal_trip) begin m_duty = 4; m_byp = 0; end
        else if (any)     begin m_duty = best; m_byp = 0; end
        else              begin m_duty = 0; m_byp = 1; end
        m_pos = 0;
      end else begin
        m_pos = m_pos + 1;
      end
      if (wr_en) m_reg[wr_thread] = int'(wr_data);
      m_halt = hn;
    end
  end

  // compare every cycle away from the edge
  always @(negedge clk) begin
    if (started && !finished) begin
      check(phase, int'(clk_en_o), m_en, "clk_en_o");
      check(phase, int'(halt_o), m_halt, "halt_o");
      check(phase, int'(rd_cfg_o[3:0]), m_reg[0], "readback t0");
      check(phase, int'(rd_cfg_o[7:4]), m_reg[1], "readback t1");
    end
  end

  task automatic wr(input int thr, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_thread = 1'(thr); wr_data = 4'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_win(input string req, input int exp);
    int ones = 0;
    repeat (20) @(negedge clk);
    repeat (8) begin
      @(negedge clk);
      ones += int'(clk_en_o);
    end
    check(req, ones, exp, "enabled cycles per window");
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", int'(clk_en_o), 1, "clk_en in reset");
    check("R1", int'(halt_o), 0, "halt in reset");
    check("R1", int'(rd_cfg_o), 0, "readback in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'(clk_en_o), 1, "clk_en after reset");

    phase = "R4"; count_win("R4", 8);

    phase = "R5";
    wr(0, 4'hB);
    check("R2", int'(rd_cfg_o[3:0]), 11, "t0 readback");
    check("R3", int'(rd_cfg_o[7:4]), 0, "t1 untouched");
    count_win("R5", 3);

    phase = "R6";
    wr(1, 4'hE); count_win("R6", 6);
    wr(1, 4'hA); count_win("R6", 3);

    phase = "R7";
    wr(0, 4'h3);
    check("R3", int'(rd_cfg_o[7:4]), 10, "t1 kept on t0 write");
    count_win("R7", 2);

    phase = "R8";
    wr(1, 4'h6); wr(0, 4'h8); count_win("R8", 8);

    phase = "R9";
    @(negedge clk) thermal_trip = 1'b1;
    count_win("R9", 4);
    wr(0, 4'hF); count_win("R9", 4);
    @(negedge clk) thermal_trip = 1'b0;
    count_win("R6", 7);

    // R11: mid-window changes, compared cycle by cycle
    phase = "R11";
    for (int i = 0; i < 150; i++) begin
      int gap;
      gap = int'($urandom_range(0, 9));
      repeat (gap) @(negedge clk);
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk) thermal_trip = ~thermal_trip;
      end else begin
        wr(int'($urandom_range(0, 1)), int'($urandom_range(0, 15)));
      end
    end
    @(negedge clk) thermal_trip = 1'b0;

    phase = "R10";
    wr(0, 4'h9);
    @(negedge clk) overtemp = 1'b1;
    @(negedge clk) overtemp = 1'b0;
    check("R10", int'(halt_o), 1, "halt after overtemp");
    check("R10", int'(clk_en_o), 0, "clk_en at halt");
    count_win("R10", 0);
    check("R10", int'(halt_o), 1, "halt sticky");
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R10", int'(halt_o), 0, "halt cleared by reset");
    count_win("R4", 8);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule